// File: doc/BRIEF.md
# Repeat Link Reset Test Controller

This block stresses a serial link by pulling its transceiver reset over and over and confirming after each pull that the link recovers cleanly. Every iteration holds the reset output high for a fixed number of cycles. It then releases the reset and allows a selectable settling window. At the end of that window the channel-up status must be high, no soft error or data error may have appeared, and channel-up may have changed level at most once. A short traffic window follows, and after it the channel-up transitions are examined a second time. The result of each iteration is either a step on to the next one or a sticky failure.

The number of iterations and the length of the settling window come from small encoded selectors. The iteration code n asks for 2^n iterations. The window code k gives 2^(CHK_BASE + CHK_STEP*k) cycles; the defaults place the windows in the range of milliseconds, and smaller values shorten them for simulation. Two free-running 20-bit counters tally every channel-up level change and every rising edge of the link-reset status. A dedicated clear input zeroes those counters without touching the test. The status and error signals come from the surrounding link logic as plain inputs.

Top module: `link_reset_tester`

## Requirements
- R1: After reset, and after every FSM clear, pma_rst, test_passed, test_failed and iter_cnt are all 0. A new iteration starts from the idle state only in a cycle where test_en is 1; while test_en is 0, pma_rst stays 0.
- R2: Each iteration drives pma_rst high for exactly RST_HOLD consecutive clock cycles.
- R3: After pma_rst falls, one release cycle is followed by a settling window of 2^(CHK_BASE + CHK_STEP*chk_sel) cycles. The test fails if chan_up is low in the last cycle of that window.
- R4: A soft_err pulse, or a nonzero data_err_cnt, in any cycle from the release cycle to the end of the iteration makes the test fail.
- R5: A channel-up change counter restarts in the release cycle. Zero or one change by the end of the settling window is accepted. Two or more changes make the test fail.
- R6: If chan_up changes during the traffic window, so that the iteration has more than one change in total, the test fails at the final check, even though the settling window was passed.
- R7: The iteration target is 2^iter_sel. iter_cnt goes up by one for each iteration that passes. test_passed rises when iter_cnt reaches the target.
- R8: test_passed and test_failed are never high together. Each stays high, with pma_rst held at 0, until fsm_clr is asserted.
- R9: fsm_clr is synchronous. It returns the FSM to idle and clears both flags, iter_cnt and the per-iteration change count.
- R10: chan_trans_cnt counts every level change of chan_up, and link_rst_cnt counts every rising edge of link_rst. Both are 20 bits wide, wrap around, and are set to 0 in the cycle after cnt_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| fsm_clr | input | 1 | Synchronous clear of the test FSM and its flags |
| cnt_clr | input | 1 | Synchronous clear of the two transition counters |
| test_en | input | 1 | Allows the next iteration to start |
| iter_sel | input | 4 | Iteration code n, target 2^n |
| chk_sel | input | 3 | Settling-window code k |
| chan_up | input | 1 | Channel-up status of the link |
| soft_err | input | 1 | Soft error indication |
| link_rst | input | 1 | Link reset status |
| data_err_cnt | input | 8 | Data error count from the frame checker |
| pma_rst | output | 1 | Transceiver reset drive |
| test_passed | output | 1 | Sticky pass flag |
| test_failed | output | 1 | Sticky fail flag |
| iter_cnt | output | 16 | Iterations passed so far |
| chan_trans_cnt | output | 20 | Channel-up transition tally |
| link_rst_cnt | output | 20 | Link-reset rising edge tally |

## Verification
The hardest case to reach is a channel-up glitch that comes after the settling window has already passed, while the traffic window is still open. Only the final check can catch it. The bench acts as the link partner and counts cycles from the negative edge at which it sees pma_rst low. It raises chan_up early, then drops it and raises it again a few cycles after the computed end of the settling window. The boundary of the settling window gets a similar treatment: chan_up rises two cycles inside the window in one case and two cycles beyond it in another.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASSERT,
    ST_DEASSERT,
    ST_WAIT,
    ST_WAIT1,
    ST_CHECK,
    ST_FAIL,
    ST_DONE
  } lrt_state_e;
endpackage

// File: rtl/lrt_countdown.sv
module lrt_countdown #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lrt_event_counter.sv
module lrt_event_counter #(
  parameter int W        = 20,
  parameter bit ANY_EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sig,
  output logic         evt,
  output logic [W-1:0] count
);
  logic sig_q;

  generate
    if (ANY_EDGE) begin : g_any
      assign evt = sig ^ sig_q;
    end else begin : g_rise
      assign evt = sig & ~sig_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 1'b0;
      count <= '0;
    end else begin
      sig_q <= sig;
      if (clr) begin
        count <= '0;
      end else if (evt) begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_reset_tester.sv
module link_reset_tester
  import lrt_pkg::*;
#(
  parameter int RST_HOLD   = 268435455,
  parameter int HOLD_W     = 28,
  parameter int CHK_BASE   = 16,
  parameter int CHK_STEP   = 2,
  parameter int WAIT1_CYC  = 4096,
  parameter int ITER_SEL_W = 4,
  parameter int CHK_SEL_W  = 3,
  parameter int ITER_W     = 16,
  parameter int TCNT_W     = 20,
  parameter int DERR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsm_clr,
  input  logic                  cnt_clr,
  input  logic                  test_en,
  input  logic [ITER_SEL_W-1:0] iter_sel,
  input  logic [CHK_SEL_W-1:0]  chk_sel,
  input  logic                  chan_up,
  input  logic                  soft_err,
  input  logic                  link_rst,
  input  logic [DERR_W-1:0]     data_err_cnt,
  output logic                  pma_rst,
  output logic                  test_passed,
  output logic                  test_failed,
  output logic [ITER_W-1:0]     iter_cnt,
  output logic [TCNT_W-1:0]     chan_trans_cnt,
  output logic [TCNT_W-1:0]     link_rst_cnt
);
  localparam int CHK_MAX_LOG2 = CHK_BASE + CHK_STEP * ((1 << CHK_SEL_W) - 1);
  localparam int TMR_W = (HOLD_W > CHK_MAX_LOG2 + 1) ? HOLD_W : CHK_MAX_LOG2 + 1;
  localparam logic [TMR_W-1:0] HOLD_LOAD  = TMR_W'(RST_HOLD - 1);
  localparam logic [TMR_W-1:0] WAIT1_LOAD = TMR_W'(WAIT1_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_ONE    = TMR_W'(1);
  localparam logic [ITER_W-1:0] ITER_ONE  = ITER_W'(1);

  lrt_state_e st_q, st_d;

  logic             tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic [TMR_W-1:0] chk_load;
  logic [ITER_W-1:0] iter_target;
  logic             iter_inc;
  logic             chan_evt, lrst_evt;
  logic [1:0]       tog_q;
  logic             err_q;
  logic             fault_now;
  logic             tog_ok;

  assign chk_load    = (TMR_ONE << (CHK_BASE + CHK_STEP * int'(chk_sel))) - TMR_ONE;
  assign iter_target = ITER_ONE << iter_sel;
  assign fault_now   = soft_err | (data_err_cnt != '0);
  assign tog_ok      = (tog_q < 2'd2);

  lrt_countdown #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  lrt_event_counter #(.W(TCNT_W), .ANY_EDGE(1'b1)) u_chan_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .sig   (chan_up),
    .evt   (chan_evt),
    .count (chan_trans_cnt)
  );

  lrt_event_counter #(.W(TCNT_W), .ANY_EDGE(1'b0)) u_lrst_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .sig   (link_rst),
    .evt   (lrst_evt),
    .count (link_rst_cnt)
  );

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    iter_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (test_en) begin
          st_d     = ST_ASSERT;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LOAD;
        end
      end
      ST_ASSERT: begin
        if (tmr_zero) st_d = ST_DEASSERT;
        else          tmr_dec = 1'b1;
      end
      ST_DEASSERT: begin
        st_d     = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = chk_load;
      end
      ST_WAIT: begin
        if (!tmr_zero) begin
          tmr_dec = 1'b1;
        end else if (chan_up && !err_q && tog_ok) begin
          st_d     = ST_WAIT1;
          tmr_load = 1'b1;
          tmr_val  = WAIT1_LOAD;
        end else begin
          st_d = ST_FAIL;
        end
      end
      ST_WAIT1: begin
        if (tmr_zero) st_d = ST_CHECK;
        else          tmr_dec = 1'b1;
      end
      ST_CHECK: begin
        if (tog_ok && !err_q) begin
          iter_inc = 1'b1;
          st_d     = ((iter_cnt + ITER_ONE) == iter_target) ? ST_DONE : ST_IDLE;
        end else begin
          st_d = ST_FAIL;
        end
      end
      ST_FAIL: st_d = ST_FAIL;
      ST_DONE: st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  // State and per-iteration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      iter_cnt <= '0;
      tog_q    <= 2'd0;
      err_q    <= 1'b0;
    end else if (fsm_clr) begin
      st_q     <= ST_IDLE;
      iter_cnt <= '0;
      tog_q    <= 2'd0;
      err_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (iter_inc) iter_cnt <= iter_cnt + ITER_ONE;
      if (st_q == ST_DEASSERT) begin
        tog_q <= {1'b0, chan_evt};
        err_q <= fault_now;
      end else begin
        if (chan_evt && (tog_q != 2'd2)) tog_q <= tog_q + 2'd1;
        if ((st_q == ST_WAIT) || (st_q == ST_WAIT1) || (st_q == ST_CHECK))
          err_q <= err_q | fault_now;
      end
    end
  end

  assign pma_rst     = (st_q == ST_ASSERT);
  assign test_passed = (st_q == ST_DONE);
  assign test_failed = (st_q == ST_FAIL);

  logic unused_ok;
  assign unused_ok = lrst_evt;
endmodule

// File: rtl/lrt_checker.sv
module lrt_checker #(
  parameter int ITER_W = 16,
  parameter int TCNT_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fsm_clr,
  input logic              cnt_clr,
  input logic              test_en,
  input logic              pma_rst,
  input logic              test_passed,
  input logic              test_failed,
  input logic [ITER_W-1:0] iter_cnt,
  input logic [TCNT_W-1:0] chan_trans_cnt,
  input logic [TCNT_W-1:0] link_rst_cnt
);
  assert_start_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pma_rst) |-> $past(test_en));

  assert_iter_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fsm_clr |=> (iter_cnt == $past(iter_cnt)) || (iter_cnt == $past(iter_cnt) + 1'b1));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_passed && test_failed));

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_failed && !fsm_clr) |=> test_failed);

  assert_pass_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_passed && !fsm_clr) |=> test_passed);

  assert_quiet_when_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_passed || test_failed) |-> !pma_rst);

  assert_fsm_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_clr |=> (!test_passed && !test_failed && !pma_rst && (iter_cnt == '0)));

  assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> ((chan_trans_cnt == '0) && (link_rst_cnt == '0)));
endmodule

bind link_reset_tester lrt_checker #(.ITER_W(ITER_W), .TCNT_W(TCNT_W)) u_lrt_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fsm_clr        (fsm_clr),
  .cnt_clr        (cnt_clr),
  .test_en        (test_en),
  .pma_rst        (pma_rst),
  .test_passed    (test_passed),
  .test_failed    (test_failed),
  .iter_cnt       (iter_cnt),
  .chan_trans_cnt (chan_trans_cnt),
  .link_rst_cnt   (link_rst_cnt)
);

// File: tb/tb_link_reset_tester.sv
module tb_link_reset_tester;
  localparam int HOLD = 8;
  localparam int BASE = 3;
  localparam int STEP = 1;
  localparam int W1   = 16;

  localparam int K_GOOD = 0, K_STAY = 1, K_LATE = 2, K_NOUP = 3, K_GLITCH = 4,
                 K_DBL = 5, K_SOFT = 6, K_DERR = 7, K_LATEGL = 8;

  logic        clk = 1'b0;
  logic        rst_n, fsm_clr, cnt_clr, test_en, chan_up, soft_err, link_rst;
  logic [3:0]  iter_sel;
  logic [2:0]  chk_sel;
  logic [7:0]  data_err_cnt;
  logic        pma_rst, test_passed, test_failed;
  logic [15:0] iter_cnt;
  logic [19:0] chan_trans_cnt, link_rst_cnt;

  int n_chk = 0, n_fail = 0;
  int exp_trans = 0, exp_lr = 0;
  bit finished = 1'b0;
  int unused_seed;

  always #4 clk = ~clk;

  link_reset_tester #(
    .RST_HOLD(HOLD), .CHK_BASE(BASE), .CHK_STEP(STEP), .WAIT1_CYC(W1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .fsm_clr(fsm_clr), .cnt_clr(cnt_clr), .test_en(test_en),
    .iter_sel(iter_sel), .chk_sel(chk_sel), .chan_up(chan_up), .soft_err(soft_err),
    .link_rst(link_rst), .data_err_cnt(data_err_cnt), .pma_rst(pma_rst),
    .test_passed(test_passed), .test_failed(test_failed), .iter_cnt(iter_cnt),
    .chan_trans_cnt(chan_trans_cnt), .link_rst_cnt(link_rst_cnt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int win_len(input int k);
    return 1 << (BASE + STEP * k);
  endfunction

  function automatic string kind_req(input int kind);
    case (kind)
      K_LATE, K_NOUP: return "R3";
      K_SOFT, K_DERR: return "R4";
      K_GLITCH, K_DBL: return "R5";
      K_LATEGL: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic set_up(input logic v);
    if (v != chan_up) exp_trans++;
    chan_up = v;
  endtask

  task automatic nedge(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_lr();
    link_rst = 1'b1;
    @(negedge clk);
    link_rst = 1'b0;
    exp_lr++;
  endtask

  task automatic do_iter(input int kind, input int c);
    int hold = 0;
    int tries = 0;
    while (!pma_rst && tries < 5000) begin
      @(negedge clk);
      tries++;
    end
    if (kind != K_STAY && kind != K_DBL) set_up(1'b0);
    while (pma_rst && hold < 1000) begin
      hold++;
      @(negedge clk);
    end
    check("R2", "reset hold cycles", hold, HOLD);
    case (kind)
      K_GOOD: begin
        nedge($urandom % (c - 1));
        set_up(1'b1);
        if ($urandom % 2 == 1) pulse_lr();
      end
      K_STAY: ;
      K_LATE: begin nedge(c + 2); set_up(1'b1); end
      K_NOUP: ;
      K_GLITCH: begin
        nedge(2); set_up(1'b1); nedge(2); set_up(1'b0); nedge(2); set_up(1'b1);
      end
      K_DBL: begin nedge(2); set_up(1'b0); nedge(2); set_up(1'b1); end
      K_SOFT: begin
        nedge(2); set_up(1'b1); nedge(3); soft_err = 1'b1; @(negedge clk); soft_err = 1'b0;
      end
      K_DERR: begin
        nedge(2); set_up(1'b1); nedge(3);
        data_err_cnt = 8'(1 + $urandom % 255); @(negedge clk); data_err_cnt = 8'd0;
      end
      K_LATEGL: begin
        nedge(2); set_up(1'b1); nedge(c + 2); set_up(1'b0); nedge(2); set_up(1'b1);
      end
      default: ;
    endcase
  endtask

  task automatic run(input int icode, input int kcode, input int fail_at, input int fail_kind);
    int n = 1 << icode;
    int c = win_len(kcode);
    int waited = 0;
    int exp_it;
    test_en = 1'b0;
    fsm_clr = 1'b1;
    @(negedge clk);
    fsm_clr = 1'b0;
    set_up(1'b1);
    iter_sel = 4'(icode);
    chk_sel  = 3'(kcode);
    @(negedge clk);
    test_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      int kind;
      if (i == fail_at) kind = fail_kind;
      else kind = ($urandom % 3 == 0) ? K_STAY : K_GOOD;
      do_iter(kind, c);
      if (i == fail_at) break;
    end
    while (!test_passed && !test_failed && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    exp_it = (fail_at < n) ? fail_at : n;
    check(fail_at < n ? kind_req(fail_kind) : "R7", "test_passed", int'(test_passed),
          fail_at < n ? 0 : 1);
    check(fail_at < n ? kind_req(fail_kind) : "R7", "test_failed", int'(test_failed),
          fail_at < n ? 1 : 0);
    check("R7", "iterations passed", int'(iter_cnt), exp_it);
    begin
      int hi = 0;
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (pma_rst) hi++;
      end
      check("R8", "pma_rst after final state", hi, 0);
      check("R8", "flag still set", int'(test_passed | test_failed), 1);
    end
    test_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    unused_seed = $urandom(32'd20240611);
    rst_n = 1'b0; fsm_clr = 1'b0; cnt_clr = 1'b0; test_en = 1'b0;
    chan_up = 1'b0; soft_err = 1'b0; link_rst = 1'b0; data_err_cnt = 8'd0;
    iter_sel = 4'd0; chk_sel = 3'd0;
    nedge(3);
    rst_n = 1'b1;
    nedge(2);
    check("R1", "pma_rst at reset", int'(pma_rst), 0);
    check("R1", "flags at reset", int'(test_passed | test_failed), 0);
    check("R1", "iter_cnt at reset", int'(iter_cnt), 0);
    check("R10", "counters at reset", int'(chan_trans_cnt) + int'(link_rst_cnt), 0);

    begin
      int hi = 0;
      for (int j = 0; j < 60; j++) begin
        @(negedge clk);
        if (pma_rst) hi++;
      end
      check("R1", "pma_rst while disabled", hi, 0);
    end

    // Passing runs, several sizes and windows
    run(0, 2, 99, K_GOOD);
    run(2, 2, 99, K_GOOD);
    run(3, 3, 99, K_GOOD);
    run(1, 4, 99, K_STAY);
    // Boundary of settling window: rises two cycles inside
    begin
      int c = win_len(2);
      test_en = 1'b0; fsm_clr = 1'b1; @(negedge clk); fsm_clr = 1'b0;
      set_up(1'b1); iter_sel = 4'd0; chk_sel = 3'd2; @(negedge clk); test_en = 1'b1;
      while (!pma_rst) @(negedge clk);
      set_up(1'b0);
      while (pma_rst) @(negedge clk);
      nedge(c - 2); set_up(1'b1);
      nedge(c + W1 + 10);
      check("R3", "late-but-inside rise passes", int'(test_passed), 1);
      test_en = 1'b0;
    end
    // Failing runs
    run(2, 2, 1, K_LATE);
    run(1, 2, 0, K_NOUP);
    run(2, 3, 2, K_GLITCH);
    run(1, 2, 1, K_DBL);
    run(2, 2, 0, K_SOFT);
    run(2, 2, 3, K_DERR);
    run(2, 2, 1, K_LATEGL);
    run(3, 2, 5, K_LATEGL);
    for (int r = 0; r < 4; r++) begin
      int ic = 1 + $urandom % 3;
      int fk = 2 + $urandom % 7;
      run(ic, 2 + $urandom % 2, $urandom % (1 << ic), fk);
    end

    // FSM clear after failure
    fsm_clr = 1'b1; @(negedge clk); fsm_clr = 1'b0; @(negedge clk);
    check("R9", "flags after fsm_clr", int'(test_passed | test_failed), 0);
    check("R9", "iter_cnt after fsm_clr", int'(iter_cnt), 0);
    check("R9", "pma_rst after fsm_clr", int'(pma_rst), 0);

    // Counters
    repeat (3) begin
      pulse_lr(); @(negedge clk);
    end
    nedge(2);
    check("R10", "channel-up transitions", int'(chan_trans_cnt), exp_trans);
    check("R10", "link reset edges", int'(link_rst_cnt), exp_lr);
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    check("R10", "chan count cleared", int'(chan_trans_cnt), 0);
    check("R10", "lrst count cleared", int'(link_rst_cnt), 0);
    exp_trans = 0; exp_lr = 0;
    set_up(~chan_up); @(negedge clk); pulse_lr(); @(negedge clk);
    check("R10", "chan count after clear", int'(chan_trans_cnt), exp_trans);
    check("R10", "lrst count after clear", int'(link_rst_cnt), exp_lr);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule